// File: doc/BRIEF.md
# Dual-Mode Serial Port (Asynchronous / Clock-Synchronous)

This block is a byte-wide serial port with two operating modes, chosen by a mode input. In asynchronous mode it sends and receives frames of one start bit, eight data bits sent least significant bit first, and one stop bit. The bit time is sixteen pulses of a baud tick input that an external timer provides. In this mode the port can send and receive at the same time. Received data is brought into the clock domain through a two-stage synchronizer, and reception is timed from the oversampled start edge.

In synchronous mode the two serial pins take on new jobs. The transmit pin carries a shift clock, fixed at eight system clocks per bit. The receive pin becomes a data line that the port drives when sending and samples when receiving, so only one direction is active at a time. In both modes the CPU side loads a byte and a start strobe, reads the last received byte, and watches two sticky completion flags that stay set until it clears them.

Top module: `serial_port`

## Requirements
- R1: After reset, `txd_o` = 1, `rxd_oe` = 0, `tx_done` = 0, `rx_done` = 0 and `rx_data` = 0.
- R2: Asynchronous transmit (`mode_sync` = 0): a `tx_start` pulse while idle drives `txd_o` with start bit 0, then `tx_data` bits 0 to 7 in that order, then stop bit 1. Each bit lasts 16 `baud_tick` pulses. The first bit begins in the cycle after the strobe, and the line idles at 1.
- R3: Asynchronous receive: the port detects a low level on `rxd_i` at a tick and confirms the start bit 8 ticks later. It then samples the eight data bits (LSB first) and the stop bit at 16-tick spacing. A stop bit of 1 loads `rx_data` and sets `rx_done`.
- R4: A low pulse on `rxd_i` that has ended before the start-bit check is rejected. `rx_done` stays 0 and a later valid frame is received correctly.
- R5: A frame whose stop bit is sampled as 0 is discarded. `rx_done` stays 0 and `rx_data` keeps its previous value.
- R6: In synchronous mode, `txd_o` is the shift clock. It is high when idle. A transfer has eight 8-cycle slots, and cycle c of the transfer (c = 0 to 63) is high when c mod 8 is 0, 1, 6 or 7 and low otherwise.
- R7: Synchronous transmit: `rxd_oe` is 1 for cycles 0 to 63 and `rxd_o` carries `tx_data` bit c/8. Each bit is therefore driven 6 cycles before the rising clock edge and held 2 cycles after it. `rxd_oe` is 0 again after cycle 63.
- R8: Synchronous receive: an `rx_start` pulse starts a transfer with `rxd_oe` = 0. `rxd_i` is sampled at each rising shift-clock edge, with the first bit going to bit 0. After cycle 63 the byte is loaded into `rx_data` and `rx_done` is set.
- R9: `tx_done` and `rx_done` stay set until their clear input is pulsed. If a completion and a clear fall in the same cycle, the flag ends up set.
- R10: Start strobes are ignored while the engine they target is busy. `rx_start` has no effect in asynchronous mode. In synchronous mode, `tx_start` and `rx_start` in the same cycle start a transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick, 16 per asynchronous bit |
| mode_sync | input | 1 | 0 asynchronous, 1 clock-synchronous; changed only while idle |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Start-transmit strobe |
| rx_start | input | 1 | Start-receive strobe (synchronous mode) |
| clr_tx_done | input | 1 | Clears the transmit-complete flag |
| clr_rx_done | input | 1 | Clears the receive-complete flag |
| txd_o | output | 1 | Serial data out (async) or shift clock (sync) |
| rxd_i | input | 1 | Serial data in, both modes |
| rxd_o | output | 1 | Data driven onto the shared line in synchronous transmit |
| rxd_oe | output | 1 | Output enable for the shared line |
| rx_data | output | 8 | Last byte received |
| tx_done | output | 1 | Sticky transmit-complete flag |
| rx_done | output | 1 | Sticky receive-complete flag |

## Verification
The two functions that can coincide are the hardware setting a completion flag and the CPU clearing that same flag. A synchronous transfer always takes exactly 64 cycles, so the bench can predict the cycle in which the flag is set and hold the clear strobe across exactly that edge, for both transmit and receive. The result is correct if the flag reads 1 after the collision and then reads 0 after a separate, later clear. The bench also issues both start strobes in the same cycle and checks that the shared line is driven and that no receive completes.

// File: rtl/sp_pkg.sv
// Shared types for the dual-mode serial port.
package sp_pkg;
    // Asynchronous receiver phases.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Direction of a synchronous transfer.
    typedef enum logic {
        DIR_RECV = 1'b0,
        DIR_SEND = 1'b1
    } sync_dir_e;
endpackage

// File: rtl/sp_uart_tx.sv
// Asynchronous transmitter. Sends start bit, DATA_W bits LSB first and a
// stop bit. Each bit lasts OSR ticks. Assumes tick is a one-cycle pulse.
// done is a one-cycle pulse once the stop bit has been fully sent.
module sp_uart_tx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    output logic              txd,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(OSR);
    localparam int IDX_W   = $clog2(FRAME_W);

    logic               busy;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   tcnt;
    logic [IDX_W-1:0]   bidx;

    // Load a frame on start, then step one bit every OSR ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            tcnt  <= '0;
            bidx  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    frame <= {1'b1, din, 1'b0};
                    tcnt  <= '0;
                    bidx  <= '0;
                end
            end else if (tick) begin
                if (tcnt == CNT_W'(OSR - 1)) begin
                    tcnt <= '0;
                    if (bidx == IDX_W'(FRAME_W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        frame <= {1'b1, frame[FRAME_W-1:1]};
                        bidx  <= bidx + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    // The line idles high between frames.
    assign txd = busy ? frame[0] : 1'b1;
endmodule

// File: rtl/sp_uart_rx.sv
// Asynchronous receiver with OSR-times oversampling. Assumes rxd has
// already been synchronized. Rejects start pulses that have gone away by
// the mid-bit check, and drops frames whose stop bit is low. done is a
// one-cycle pulse with the byte on dout.
module sp_uart_rx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic [DATA_W-1:0] dout,
    output logic              done
);
    import sp_pkg::*;

    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;

    // Frame tracking, advanced only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(OSR / 2 - 1)) begin
                            cnt   <= '0;
                            bidx  <= '0;
                            state <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_W'(OSR - 1)) begin
                            cnt <= '0;
                            sh  <= {rxd, sh[DATA_W-1:1]};
                            if (bidx == BIT_W'(DATA_W - 1)) state <= RX_STOP;
                            else                            bidx  <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(OSR - 1)) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                            done  <= rxd;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign dout = sh;
endmodule

// File: rtl/sp_sync_shift.sv
// Clock-synchronous shifter. The shift clock period is 8 cycles per bit.
// Within each slot, phases 0-1 are high, 2-5 are low and 6-7 are high.
// Outgoing data changes at phase 0 and incoming data is captured at the
// rising edge (phase 5 -> 6). The clock idles high. Transmit wins if both
// starts arrive together; starts are ignored while active.
module sp_sync_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic [DATA_W-1:0] din,
    input  logic              sdi,
    output logic              sdo,
    output logic              sclk,
    output logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              done_tx,
    output logic              done_rx
);
    import sp_pkg::*;

    localparam int          BIT_W   = $clog2(DATA_W);
    localparam logic [2:0]  PH_LOW  = 3'd2;
    localparam logic [2:0]  PH_HIGH = 3'd6;
    localparam logic [2:0]  PH_CAP  = PH_HIGH - 3'd1;
    localparam logic [2:0]  PH_LAST = 3'd7;

    logic              active;
    sync_dir_e         dir;
    logic [2:0]        ph;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;

    // Slot and phase sequencing with shift-in and shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            dir     <= DIR_RECV;
            ph      <= '0;
            bidx    <= '0;
            sh      <= '0;
            done_tx <= 1'b0;
            done_rx <= 1'b0;
        end else begin
            done_tx <= 1'b0;
            done_rx <= 1'b0;
            if (!active) begin
                if (start_tx || start_rx) begin
                    active <= 1'b1;
                    dir    <= start_tx ? DIR_SEND : DIR_RECV;
                    sh     <= start_tx ? din : '0;
                    ph     <= '0;
                    bidx   <= '0;
                end
            end else begin
                ph <= ph + 1'b1;
                if (ph == PH_CAP && dir == DIR_RECV)
                    sh <= {sdi, sh[DATA_W-1:1]};
                if (ph == PH_LAST) begin
                    if (dir == DIR_SEND)
                        sh <= {1'b0, sh[DATA_W-1:1]};
                    if (bidx == BIT_W'(DATA_W - 1)) begin
                        active  <= 1'b0;
                        done_tx <= (dir == DIR_SEND);
                        done_rx <= (dir == DIR_RECV);
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
            end
        end
    end

    assign sclk = !active || ph < PH_LOW || ph >= PH_HIGH;
    assign oe   = active && dir == DIR_SEND;
    assign sdo  = sh[0];
    assign dout = sh;
endmodule

// File: rtl/serial_port.sv
// Dual-mode serial port top. Routes the pins to the asynchronous engines
// or the synchronous shifter according to mode_sync, and holds the
// received byte and the sticky completion flags. Assumes mode_sync only
// changes while no transfer is in progress.
module serial_port #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              mode_sync,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    input  logic              rx_start,
    input  logic              clr_tx_done,
    input  logic              clr_rx_done,
    output logic              txd_o,
    input  logic              rxd_i,
    output logic              rxd_o,
    output logic              rxd_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_done,
    output logic              rx_done
);
    logic              rxd_meta, rxd_sync;
    logic              u_txd, u_tx_done, u_rx_done;
    logic [DATA_W-1:0] u_rx_data;
    logic              s_sclk, s_tx_done, s_rx_done;
    logic [DATA_W-1:0] s_rx_data;

    // Two-stage synchronizer for the asynchronous receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_meta <= 1'b1;
            rxd_sync <= 1'b1;
        end else begin
            rxd_meta <= rxd_i;
            rxd_sync <= rxd_meta;
        end
    end

    sp_uart_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_utx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .start (tx_start && !mode_sync),
        .din   (tx_data),
        .txd   (u_txd),
        .done  (u_tx_done)
    );

    sp_uart_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_urx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .rxd   (mode_sync ? 1'b1 : rxd_sync),
        .dout  (u_rx_data),
        .done  (u_rx_done)
    );

    sp_sync_shift #(.DATA_W(DATA_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_tx (tx_start && mode_sync),
        .start_rx (rx_start && mode_sync),
        .din      (tx_data),
        .sdi      (rxd_i),
        .sdo      (rxd_o),
        .sclk     (s_sclk),
        .oe       (rxd_oe),
        .dout     (s_rx_data),
        .done_tx  (s_tx_done),
        .done_rx  (s_rx_done)
    );

    // The transmit pin carries either serial data or the shift clock.
    assign txd_o = mode_sync ? s_sclk : u_txd;

    // Sticky flags (set has priority over clear) and received-byte holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
            rx_data <= '0;
        end else begin
            if (u_tx_done || s_tx_done) tx_done <= 1'b1;
            else if (clr_tx_done)       tx_done <= 1'b0;
            if (u_rx_done || s_rx_done) rx_done <= 1'b1;
            else if (clr_rx_done)       rx_done <= 1'b0;
            if (u_rx_done)      rx_data <= u_rx_data;
            else if (s_rx_done) rx_data <= s_rx_data;
        end
    end
endmodule

// File: rtl/serial_port_checker.sv
// Port-level protocol checks for serial_port, attached with bind.
module serial_port_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_sync,
    input logic txd_o,
    input logic rxd_o,
    input logic rxd_oe,
    input logic tx_done,
    input logic rx_done,
    input logic clr_tx_done,
    input logic clr_rx_done
);
    // R7: the shared line is only driven in synchronous mode.
    p_oe_sync_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_oe |-> mode_sync);

    // R7: data does not change at the rising shift-clock edge.
    p_data_stable_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && rxd_oe && $past(rxd_oe) && $rose(txd_o)) |-> $stable(rxd_o));

    // R6: a low clock phase lasts more than one cycle.
    p_sclk_low_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && $past(mode_sync) && $fell(txd_o)) |=> !txd_o);

    // R9: the transmit flag is held until cleared.
    p_tx_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !clr_tx_done) |=> tx_done);

    // R9: the receive flag is held until cleared.
    p_rx_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_rx_done) |=> rx_done);
endmodule

bind serial_port serial_port_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sync   (mode_sync),
    .txd_o       (txd_o),
    .rxd_o       (rxd_o),
    .rxd_oe      (rxd_oe),
    .tx_done     (tx_done),
    .rx_done     (rx_done),
    .clr_tx_done (clr_tx_done),
    .clr_rx_done (clr_rx_done)
);

// File: tb/serial_port_tb.sv
`timescale 1ns/1ps
module serial_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       mode_sync = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_start = 1'b0;
    logic       rx_start = 1'b0;
    logic       clr_tx_done = 1'b0;
    logic       clr_rx_done = 1'b0;
    logic       txd_o, rxd_o, rxd_oe, tx_done, rx_done;
    logic [7:0] rx_data;
    logic       loop_en = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       rxd_i;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    assign rxd_i = loop_en ? txd_o : rxd_drv;

    always #2.5 clk = ~clk;

    serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode_sync(mode_sync),
        .tx_data(tx_data), .tx_start(tx_start), .rx_start(rx_start),
        .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
        .txd_o(txd_o), .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe(rxd_oe),
        .rx_data(rx_data), .tx_done(tx_done), .rx_done(rx_done)
    );

    // Baud tick: one pulse every 4 clocks, driven away from the active edge.
    initial begin
        forever begin
            repeat (3) @(negedge clk) baud_tick = 1'b0;
            @(negedge clk) baud_tick = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected line level for bit i of an asynchronous frame.
    function automatic logic frame_bit(input logic [7:0] b, input int i);
        if (i == 0) return 1'b0;
        if (i == 9) return 1'b1;
        return b[i-1];
    endfunction

    // Expected shift clock in cycle c of a synchronous transfer.
    function automatic logic exp_sclk(input int c);
        return (c % 8) < 2 || (c % 8) >= 6;
    endfunction

    task automatic clear_flags();
        @(negedge clk) begin clr_tx_done = 1'b1; clr_rx_done = 1'b1; end
        @(negedge clk) begin clr_tx_done = 1'b0; clr_rx_done = 1'b0; end
    endtask

    // Send one asynchronous frame, decode the line, optionally poke a
    // second start mid-frame, and check the loopback receive if enabled.
    task automatic uart_tx_frame(input logic [7:0] b, input bit poke);
        int cur = 0;
        int bad = 0;
        @(negedge clk) begin tx_data = b; tx_start = 1'b1; end
        @(negedge clk) tx_start = 1'b0;
        chk("R2 start bit begins", txd_o, 1'b0);
        for (int i = 0; i < 10; i++) begin
            repeat (64 * i + 30 - cur) @(negedge clk);
            cur = 64 * i + 30;
            chk($sformatf("R2 frame bit %0d", i), txd_o, frame_bit(b, i));
            if (poke && i == 3) begin
                tx_data = ~b; tx_start = 1'b1;
                @(negedge clk) begin tx_start = 1'b0; tx_data = b; end
                cur++;
            end
        end
        repeat (650 - cur) @(negedge clk);
        chk("R9 tx_done after frame", tx_done, 1'b1);
        if (loop_en) begin
            chk("R3 loopback rx_done", rx_done, 1'b1);
            chk("R3 loopback rx_data", rx_data, b);
        end
        if (poke) begin
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                if (txd_o !== 1'b1) bad++;
            end
            chk("R10 start while busy ignored", bad, 0);
        end
        clear_flags();
        chk("R9 tx_done cleared", tx_done, 1'b0);
    endtask

    // Drive an asynchronous frame from the bench, with a chosen stop bit.
    task automatic uart_drive(input logic [7:0] b, input logic stop);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) rxd_drv = (i == 9) ? stop : frame_bit(b, i);
            repeat (63) @(negedge clk);
        end
        @(negedge clk) rxd_drv = 1'b1;
        repeat (80) @(negedge clk);
    endtask

    // Synchronous transmit; optional collision of clear with completion,
    // simultaneous rx_start, and mid-transfer start pokes.
    task automatic sync_tx(input logic [7:0] b, input bit collide, input bit both, input bit poke);
        int bad = 0;
        @(negedge clk) begin tx_data = b; tx_start = 1'b1; rx_start = both; end
        @(negedge clk) begin tx_start = 1'b0; rx_start = 1'b0; end
        for (int c = 0; c < 64; c++) begin
            if (txd_o !== exp_sclk(c)) begin
                bad++;
                $display("FAIL R6 sclk cycle %0d actual=%0b expected=%0b", c, txd_o, exp_sclk(c));
            end
            if (rxd_oe !== 1'b1 || rxd_o !== b[c/8]) begin
                bad++;
                $display("FAIL R7 cycle %0d oe=%0b data=%0b expected data=%0b", c, rxd_oe, rxd_o, b[c/8]);
            end
            if (poke && c == 20) begin
                tx_data = ~b; tx_start = 1'b1; rx_start = 1'b1;
            end else begin
                tx_start = 1'b0; rx_start = 1'b0; tx_data = b;
            end
            @(negedge clk);
        end
        n_chk++;
        if (bad != 0) n_fail++;
        chk("R7 line released after transfer", rxd_oe, 1'b0);
        chk("R6 clock idles high", txd_o, 1'b1);
        if (collide) begin
            clr_tx_done = 1'b1;
            @(negedge clk) clr_tx_done = 1'b0;
            chk("R9 set wins over clear (tx)", tx_done, 1'b1);
        end else begin
            @(negedge clk);
            chk("R7 tx_done after 64 cycles", tx_done, 1'b1);
        end
        if (both) chk("R10 simultaneous starts: no receive", rx_done, 1'b0);
        clear_flags();
        chk("R9 tx_done cleared", tx_done, 1'b0);
    endtask

    // Synchronous receive; bench presents bit k only around its rising edge.
    task automatic sync_rx(input logic [7:0] b, input bit collide);
        int bad = 0;
        @(negedge clk) begin rx_start = 1'b1; rxd_drv = ~b[0]; end
        @(negedge clk) rx_start = 1'b0;
        for (int c = 0; c < 64; c++) begin
            if (txd_o !== exp_sclk(c) || rxd_oe !== 1'b0) begin
                bad++;
                $display("FAIL R8 cycle %0d sclk=%0b oe=%0b expected sclk=%0b oe=0", c, txd_o, rxd_oe, exp_sclk(c));
            end
            rxd_drv = ((c % 8) == 4 || (c % 8) == 5) ? b[c/8] : ~b[c/8];
            @(negedge clk);
        end
        n_chk++;
        if (bad != 0) n_fail++;
        if (collide) begin
            clr_rx_done = 1'b1;
            @(negedge clk) clr_rx_done = 1'b0;
            chk("R9 set wins over clear (rx)", rx_done, 1'b1);
        end else begin
            @(negedge clk);
            chk("R8 rx_done after 64 cycles", rx_done, 1'b1);
        end
        chk("R8 received byte", rx_data, b);
        rxd_drv = 1'b1;
        clear_flags();
        chk("R9 rx_done cleared", rx_done, 1'b0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] r;
        int bad;
        r = 8'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd_o", txd_o, 1'b1);
        chk("R1 rxd_oe", rxd_oe, 1'b0);
        chk("R1 tx_done", tx_done, 1'b0);
        chk("R1 rx_done", rx_done, 1'b0);
        chk("R1 rx_data", rx_data, 8'h00);

        // Asynchronous transmit, directed corners and loopback.
        loop_en = 1'b1;
        uart_tx_frame(8'hA5, 1'b0);
        uart_tx_frame(8'h00, 1'b0);
        uart_tx_frame(8'hFF, 1'b1);
        for (int n = 0; n < 4; n++) uart_tx_frame(8'($urandom), 1'b0);
        loop_en = 1'b0;

        // R3 bench-driven frame
        uart_drive(8'h3C, 1'b1);
        chk("R3 rx_done", rx_done, 1'b1);
        chk("R3 rx_data", rx_data, 8'h3C);
        clear_flags();

        // R4 short low glitch rejected
        @(negedge clk) rxd_drv = 1'b0;
        repeat (8) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (120) @(negedge clk);
        chk("R4 glitch sets no rx_done", rx_done, 1'b0);
        uart_drive(8'h96, 1'b1);
        chk("R4 next frame received", rx_data, 8'h96);
        clear_flags();

        // R5 framing error discarded
        uart_drive(8'h5A, 1'b0);
        chk("R5 bad stop sets no rx_done", rx_done, 1'b0);
        chk("R5 rx_data unchanged", rx_data, 8'h96);

        // R10 rx_start ignored in asynchronous mode
        bad = 0;
        @(negedge clk) rx_start = 1'b1;
        @(negedge clk) rx_start = 1'b0;
        for (int k = 0; k < 80; k++) begin
            if (txd_o !== 1'b1 || rxd_oe !== 1'b0) bad++;
            @(negedge clk);
        end
        chk("R10 rx_start ignored in async mode", bad, 0);
        chk("R10 no rx_done from rx_start in async mode", rx_done, 1'b0);

        // Synchronous mode
        @(negedge clk) mode_sync = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 clock idle high", txd_o, 1'b1);
        sync_tx(8'h81, 1'b0, 1'b0, 1'b0);
        sync_tx(8'h6E, 1'b1, 1'b0, 1'b0);
        sync_tx(8'hC3, 1'b0, 1'b1, 1'b1);
        sync_rx(8'hB4, 1'b0);
        sync_rx(8'h1F, 1'b1);
        for (int n = 0; n < 5; n++) begin
            sync_tx(r, 1'b0, 1'b0, 1'b0);
            r = 8'($urandom);
            sync_rx(r, 1'b0);
            r = 8'($urandom);
        end
        summary();
    end
endmodule